// File: doc/BRIEF.md
# Dithered High-Resolution PWM Generator

This block produces a pulse-width modulated signal whose average period or average high time can be set to a resolution of 1/32 of a clock. It takes a 16-bit integer period, a 16-bit integer duty value, a 5-bit fraction and a mode bit. In every PWM cycle it uses one of two parameter sets. The base set is the programmed period and duty. The step set is derived inside the block by adding one clock, either to the period or to the duty value. A phase accumulator decides which set each cycle uses. Over any window of 32 consecutive cycles, exactly as many cycles use the step set as the fraction says, and these cycles are spread evenly through the window.

In frequency-dither mode the high time is held and the cycle length moves between P and P+1 clocks. In duty-dither mode the cycle length is fixed and the high time moves between D and D+1 clocks. The block drives the PWM signal and its complement, so that a following deadtime stage can use both. Settings are taken in only when one PWM cycle ends and the next begins. A synchronous enable parks the generator with its output low.

Top module: `hrpwm_dither`

## Requirements
- R1: While `rst_ni` is low, `pwm_o` is 0 and `pwm_n_o` is 1.
- R2: `pwm_n_o` is always the logical inverse of `pwm_o`.
- R3: Within a cycle the internal counter runs from 0 up to the active period minus 1 and then restarts at 0. `pwm_o` is high while the counter is below the active duty value. The first counter value of a cycle is visible one clock after the boundary edge.
- R4: With `mode_i`=0 (frequency dither), every cycle lasts P or P+1 clocks with a high time of D. In any 32 consecutive cycles, exactly F of them last P+1.
- R5: With `mode_i`=1 (duty dither), every cycle lasts P clocks with a high time of D or D+1. In any 32 consecutive cycles, exactly F of them have a high time of D+1.
- R6: With F=0 the step set is never used: every cycle lasts P clocks and is high for D clocks.
- R7: At each boundary a 5-bit accumulator adds F. Its carry selects the step set for the cycle that starts there, and it starts from 0 on enable. For F≤16, no two adjacent cycles both use the step set.
- R8: `period_i`, `duty_i`, `frac_i` and `mode_i` are sampled only at a cycle boundary. A change in the middle of a cycle does not alter the length or high time of that cycle.
- R9: If the active duty value is at least the active period, the output stays high. If the duty value is 0, the output stays low.
- R10: When `en_i` is sampled low, `pwm_o` is low from the next clock and the counter and accumulator are cleared. When `en_i` is sampled high again, a new cycle starts with the counter at 0, so `pwm_o` goes high one clock later if D>0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Synchronous run enable |
| mode_i | input | 1 | 0 = frequency dither, 1 = duty dither |
| period_i | input | 16 | Integer period P in clocks |
| duty_i | input | 16 | Integer high time D in clocks |
| frac_i | input | 5 | Fraction F: step-set cycles per 32 |
| pwm_o | output | 1 | PWM output |
| pwm_n_o | output | 1 | Inverse of the PWM output |

## Verification
Some properties are checked by assertions on every clock:
- the output pair is complementary;
- the counter stays below the active period and steps by one between boundaries;
- active settings change only at a boundary, and each derived set is exactly the base set or one clock above it;
- a disable clears the counter and the accumulator and drops the output;
- a zero fraction never produces a carry.

Other properties span many cycles, so only the bench scenarios can show them: the exact count of step-set cycles in a 32-cycle window, the even spreading of those cycles, the way a mid-cycle change is deferred, and the saturated and zero duty cases. The bench measures these from output edge timing, and it also compares the output every clock against a behavioural model.

// File: rtl/hrpwm_pkg.sv
package hrpwm_pkg;
  typedef enum logic {
    DITHER_FREQ = 1'b0,
    DITHER_DUTY = 1'b1
  } dither_mode_e;
endpackage

// File: rtl/hrpwm_phase_acc.sv
module hrpwm_phase_acc #(
  parameter int FRAC_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              step_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              carry_o
);
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;

  assign sum     = {1'b0, acc_q} + {1'b0, frac_i};
  assign carry_o = sum[FRAC_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else if (step_i) acc_q <= sum[FRAC_W-1:0];
  end

  // R10: disable clears the phase
  a_r10_acc_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> acc_q == '0);
  // R6: zero fraction never selects the step set
  a_r6_zero_frac_no_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && frac_i == '0) |-> !carry_o);
  // R7: phase advances only at boundaries
  a_r7_acc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !step_i) |=> $stable(acc_q));
endmodule

// File: rtl/hrpwm_param_sel.sv
module hrpwm_param_sel
  import hrpwm_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int ACT_W = CNT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             plus_i,
  input  logic             mode_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic [ACT_W-1:0] per_o,
  output logic [ACT_W-1:0] duty_o
);
  logic [ACT_W-1:0] per_q, duty_q;
  logic             per_inc, duty_inc;

  assign per_inc  = plus_i && (mode_i == DITHER_FREQ);
  assign duty_inc = plus_i && (mode_i == DITHER_DUTY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q  <= '0;
      duty_q <= '0;
    end else if (load_i) begin
      per_q  <= {1'b0, period_i} + {{CNT_W{1'b0}}, per_inc};
      duty_q <= {1'b0, duty_i} + {{CNT_W{1'b0}}, duty_inc};
    end
  end

  assign per_o  = per_q;
  assign duty_o = duty_q;

  // R8: active set frozen inside a cycle
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(per_q) && $stable(duty_q)));
  // R4: frequency mode keeps duty, period is P or P+1
  a_r4_freq_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && mode_i == DITHER_FREQ) |=>
      (duty_q == {1'b0, $past(duty_i)}) &&
      ((per_q == {1'b0, $past(period_i)}) || (per_q == {1'b0, $past(period_i)} + 1'b1)));
  // R5: duty mode keeps period, duty is D or D+1
  a_r5_duty_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && mode_i == DITHER_DUTY) |=>
      (per_q == {1'b0, $past(period_i)}) &&
      ((duty_q == {1'b0, $past(duty_i)}) || (duty_q == {1'b0, $past(duty_i)} + 1'b1)));
endmodule

// File: rtl/hrpwm_timebase.sv
module hrpwm_timebase #(
  parameter int CNT_W = 16,
  localparam int ACT_W = CNT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [ACT_W-1:0] per_i,
  input  logic [ACT_W-1:0] duty_i,
  output logic             load_o,
  output logic             pwm_o,
  output logic             pwm_n_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [ACT_W-1:0] cnt_nxt;
  logic             run_q, wrap;

  assign cnt_nxt = {1'b0, cnt_q} + 1'b1;
  assign wrap    = cnt_nxt >= per_i;
  assign load_o  = en_i && (!run_q || wrap);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      run_q <= 1'b1;
      cnt_q <= load_o ? '0 : cnt_nxt[CNT_W-1:0];
    end
  end

  // separate compares so the complement is a checked relation
  assign pwm_o   = run_q && ({1'b0, cnt_q} < duty_i);
  assign pwm_n_o = !run_q || ({1'b0, cnt_q} >= duty_i);

  a_r2_complement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwm_n_o != pwm_o);
  a_r3_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && per_i > 1) |-> ({1'b0, cnt_q} < per_i));
  a_r3_count_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && en_i && !load_o) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
  a_r10_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!pwm_o && cnt_q == '0));
endmodule

// File: rtl/hrpwm_dither.sv
module hrpwm_dither #(
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 5,
  localparam int ACT_W = CNT_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              mode_i,
  input  logic [CNT_W-1:0]  period_i,
  input  logic [CNT_W-1:0]  duty_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              pwm_o,
  output logic              pwm_n_o
);
  logic             load, plus;
  logic [ACT_W-1:0] act_per, act_duty;

  hrpwm_phase_acc #(.FRAC_W(FRAC_W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (!en_i),
    .step_i  (load),
    .frac_i  (frac_i),
    .carry_o (plus)
  );

  hrpwm_param_sel #(.CNT_W(CNT_W)) u_sel (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .plus_i   (plus),
    .mode_i   (mode_i),
    .period_i (period_i),
    .duty_i   (duty_i),
    .per_o    (act_per),
    .duty_o   (act_duty)
  );

  hrpwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .per_i   (act_per),
    .duty_i  (act_duty),
    .load_o  (load),
    .pwm_o   (pwm_o),
    .pwm_n_o (pwm_n_o)
  );
endmodule

// File: tb/test_hrpwm_dither.sv
`timescale 1ns/1ps
module test_hrpwm_dither;
  logic        clk = 1'b0, rst_n = 1'b0, en = 1'b0, mode = 1'b0;
  logic [15:0] per = '0, duty = '0;
  logic [4:0]  frac = '0;
  logic        pwm, pwm_n;

  always #2 clk = ~clk;

  hrpwm_dither i_hrpwm_dither (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .mode_i(mode),
    .period_i(per), .duty_i(duty), .frac_i(frac),
    .pwm_o(pwm), .pwm_n_o(pwm_n)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference
  int m_cnt = 0, m_per = 0, m_duty = 0, m_acc = 0, m_s = 0;
  bit m_run = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_per = 0; m_duty = 0; m_acc = 0; m_run = 0;
    end else if (!en) begin
      m_cnt = 0; m_acc = 0; m_run = 0;
    end else if (!m_run || m_cnt + 1 >= m_per) begin
      m_s    = m_acc + int'(frac);
      m_acc  = m_s % 32;
      m_per  = int'(per)  + ((mode == 1'b0 && m_s >= 32) ? 1 : 0);
      m_duty = int'(duty) + ((mode == 1'b1 && m_s >= 32) ? 1 : 0);
      m_cnt  = 0; m_run = 1;
    end else begin
      m_cnt = m_cnt + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(pwm == (m_run && m_cnt < m_duty), "R3 model", int'(pwm), int'(m_run && m_cnt < m_duty));
      chk(pwm_n == !pwm, "R2 complement", int'(pwm_n), int'(!pwm));
    end
  end

  // edge monitor: cycle length and high time between rising edges
  int len_q[$], hi_q[$];
  int len_cnt = 0, hi_cnt = 0;
  bit prev = 0, valid = 0;
  always @(negedge clk) begin
    if (pwm && !prev) begin
      if (valid) begin len_q.push_back(len_cnt); hi_q.push_back(hi_cnt); end
      valid = 1; len_cnt = 1; hi_cnt = 1;
    end else begin
      len_cnt++;
      if (pwm) hi_cnt++;
    end
    prev = pwm;
  end

  task automatic setup(bit m, int p, int d, int f);
    @(negedge clk);
    mode = m; per = 16'(p); duty = 16'(d); frac = 5'(f);
  endtask

  task automatic run_case(bit m, int p, int d, int f, string req);
    int nlong, adj;
    setup(m, p, d, f);
    repeat (2 * (p + 2) + 4) @(negedge clk);
    @(posedge clk);
    len_q.delete(); hi_q.delete(); valid = 0;
    while (len_q.size() < 32) @(negedge clk);
    nlong = 0; adj = 0;
    for (int i = 0; i < 32; i++) begin
      bit stp;
      if (m == 1'b0) begin
        chk(len_q[i] == p || len_q[i] == p + 1, {req, " length"}, len_q[i], p);
        chk(hi_q[i] == d, {req, " high"}, hi_q[i], d);
        stp = (len_q[i] == p + 1);
      end else begin
        chk(len_q[i] == p, {req, " length"}, len_q[i], p);
        chk(hi_q[i] == d || hi_q[i] == d + 1, {req, " high"}, hi_q[i], d);
        stp = (hi_q[i] == d + 1);
      end
      if (stp) nlong++;
      if (i > 0 && stp && ((m == 1'b0) ? (len_q[i-1] == p + 1) : (hi_q[i-1] == d + 1))) adj++;
    end
    chk(nlong == f, {req, " step count"}, nlong, f);
    if (f <= 16) chk(adj == 0, "R7 adjacent step cycles", adj, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R3 watchdog actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(pwm == 1'b0, "R1 reset pwm", int'(pwm), 0);
    chk(pwm_n == 1'b1, "R1 reset pwm_n", int'(pwm_n), 1);
    rst_n = 1'b1;
    setup(1'b0, 10, 4, 8);
    en = 1'b1;

    run_case(1'b0, 10, 4, 8, "R4");
    run_case(1'b0, 7, 3, 31, "R4");
    run_case(1'b0, 9, 5, 0, "R6");
    run_case(1'b1, 12, 5, 5, "R5");
    run_case(1'b1, 16, 8, 16, "R5");
    run_case(1'b1, 12, 5, 0, "R6");
    run_case(1'b0, 11, 6, 1, "R7");

    // R8: mid-cycle change deferred to the boundary
    setup(1'b0, 20, 10, 0);
    repeat (50) @(negedge clk);
    @(posedge clk);
    len_q.delete(); hi_q.delete();
    while (len_q.size() < 1) @(negedge clk);
    repeat (3) @(negedge clk);
    @(posedge clk);
    len_q.delete(); hi_q.delete();
    setup(1'b0, 12, 6, 0);
    while (len_q.size() < 2) @(negedge clk);
    chk(len_q[0] == 20, "R8 old length kept", len_q[0], 20);
    chk(hi_q[0] == 10, "R8 old high kept", hi_q[0], 10);
    chk(len_q[1] == 12, "R8 new length", len_q[1], 12);

    // R9: saturated and zero duty
    setup(1'b0, 8, 8, 0);
    repeat (30) @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); chk(pwm == 1'b1, "R9 duty=period high", int'(pwm), 1);
    end
    setup(1'b1, 8, 9, 20);
    repeat (30) @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); chk(pwm == 1'b1, "R9 duty>period high", int'(pwm), 1);
    end
    setup(1'b1, 8, 0, 0);
    repeat (30) @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); chk(pwm == 1'b0, "R9 zero duty low", int'(pwm), 0);
    end

    // R10: enable off and on
    setup(1'b0, 10, 3, 0);
    repeat (30) @(negedge clk);
    en = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); chk(pwm == 1'b0, "R10 disabled low", int'(pwm), 0);
    end
    en = 1'b1;
    @(negedge clk); chk(pwm == 1'b1, "R10 restart high", int'(pwm), 1);
    @(negedge clk); chk(pwm == 1'b1, "R10 restart high", int'(pwm), 1);
    @(negedge clk); chk(pwm == 1'b1, "R10 restart high", int'(pwm), 1);
    @(negedge clk); chk(pwm == 1'b0, "R10 restart low at D", int'(pwm), 0);

    repeat (5) @(negedge clk);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule